// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a 30-bit physical address by reading two entries of a page table that lives in ordinary memory. A request carries the virtual address. The walker splits that address into a 10-bit first-level index, a 10-bit second-level index and a 12-bit page offset. It reads the first-level entry at the table base plus four times the first index. That entry gives the frame of a second-level table, and the walker then reads the second-level entry in the same way. The second entry gives the physical page frame and the access permissions. If either entry is unusable, the walk ends with a page fault that reports the level where it stopped.

Every table entry is a 32-bit word with this layout:

- Bit 0 is the valid bit.
- Bit 1 grants read access.
- Bit 2 grants write access.
- Bit 3 marks the page as supervisor-only.
- Bits 31:12 hold the frame number.

A physical address has only 18 frame bits, so bits 31:30 of the frame field must be zero. Bits 11:4 are ignored.

The walker uses one memory read port and keeps at most one read outstanding. A read request is handed over with a valid/ready handshake. The read data comes back on a one-cycle response beat.

The control is a four-state machine: `ST_IDLE`, `ST_L1_READ`, `ST_L2_READ` and `ST_DONE`. Its transitions are:

- **accept**: `ST_IDLE` goes to `ST_L1_READ` when `req_valid` is high.
- **descend**: `ST_L1_READ` goes to `ST_L2_READ` when a usable first-level entry arrives.
- **l1_fault**: `ST_L1_READ` goes to `ST_DONE` when an unusable first-level entry arrives.
- **l2_end**: `ST_L2_READ` goes to `ST_DONE` when the second-level entry arrives.
- **release**: `ST_DONE` goes back to `ST_IDLE` after one cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, while `mem_req_valid` and `rsp_valid` are 0.
- R2: A request is taken only when `req_ready` is high, which happens only in `ST_IDLE`. Once a request is taken, `req_ready` stays low until the walk completes, and `req_valid` or `req_vaddr` activity in that time has no effect on the result.
- R3: The first read is issued in the cycle after acceptance. Its address is `table_base + 4*vaddr[31:22]`, using the `table_base` value sampled at acceptance; later changes to `table_base` during the walk have no effect.
- R4: A first-level entry with bit 0 clear, or with a nonzero bit 31 or bit 30, ends the walk after a single read. The response then has `rsp_fault`=1 and `rsp_fault_level`=0.
- R5: After a usable first-level entry E1, the second read address is `{E1[29:12], 12'h000} + 4*vaddr[21:12]`.
- R6: A second-level entry with bit 0 clear, or with a nonzero bit 31 or bit 30, gives `rsp_fault`=1 and `rsp_fault_level`=1. On any fault, `rsp_paddr` and all three permission outputs are 0.
- R7: A usable second-level entry E2 gives `rsp_fault`=0 and `rsp_paddr = {E2[29:12], vaddr[11:0]}`. It also gives `rsp_read`=E2[1], `rsp_write`=E2[2] and `rsp_super`=E2[3], with bits 11:4 of either entry ignored.
- R8: `rsp_valid` is a one-cycle pulse that appears in the cycle after the read-data beat that ends the walk. `req_ready` returns to 1 in the following cycle.
- R9: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen. No new read is requested until the data of the previous one has arrived.
- R10: A `mem_rsp_valid` beat while no read is outstanding is ignored: no response is produced, no read is started and `req_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| table_base | input | 30 | Physical byte address of the first-level table |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker can accept a request (`ST_IDLE`) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 30 | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Read data beat |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_level | output | 1 | Level at which the fault occurred (0 first, 1 second) |
| rsp_paddr | output | 30 | Translated physical address |
| rsp_read | output | 1 | Read permission of the page |
| rsp_write | output | 1 | Write permission of the page |
| rsp_super | output | 1 | Page is supervisor-only |

## Verification
The first read request is due in the cycle after the edge that accepts the request. The result pulse is due exactly one cycle after the read-data beat that ends the walk, and `req_ready` returns one cycle after that. The bench drives inputs and samples outputs on the falling edge. It keeps a count of rising edges and records the count when it drives the final data beat. It then requires `rsp_valid` to be seen at a count exactly one higher, with `rsp_valid` low and `req_ready` high one sample later. The memory model inserts random ready stalls and data latencies, so these fixed offsets are tested against many different walk lengths.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_L1_READ,
        ST_L2_READ,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic super_only;
        logic can_write;
        logic can_read;
    } pte_perm_t;

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int PTE_W = 32,
    parameter int PA_W  = 30,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]      pte,
    output logic                  entry_ok,
    output logic [PA_W-OFF_W-1:0] frame,
    output pte_perm_t             perm
);
    localparam int PERM_LSB = 1;
    localparam int PERM_W   = $bits(pte_perm_t);

    logic hi_clear;

    generate
        if (PTE_W > PA_W) begin : g_range
            assign hi_clear = ~|pte[PTE_W-1:PA_W];
        end else begin : g_norange
            assign hi_clear = 1'b1;
        end
    endgenerate

    assign entry_ok = pte[0] & hi_clear;
    assign frame    = pte[PA_W-1:OFF_W];
    assign perm     = pte[PERM_LSB +: PERM_W];

    logic unused_low_bits;
    assign unused_low_bits = ^pte[OFF_W-1:PERM_LSB+PERM_W];

endmodule

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
    parameter int VA_W     = 32,
    parameter int PA_W     = 30,
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    parameter int OFF_W    = 12,
    parameter int PTE_W    = 32
) (
    input  logic                  second_level,
    input  logic [PA_W-1:0]       base,
    input  logic [PA_W-OFF_W-1:0] next_frame,
    input  logic [VA_W-1:0]       vaddr,
    output logic [PA_W-1:0]       entry_addr
);
    localparam int ENT_SH = $clog2(PTE_W / 8);

    logic [L1_IDX_W-1:0] l1_idx;
    logic [L2_IDX_W-1:0] l2_idx;
    logic [PA_W-1:0]     l1_off;
    logic [PA_W-1:0]     l2_off;
    logic [PA_W-1:0]     l2_base;

    assign l1_idx  = vaddr[VA_W-1 -: L1_IDX_W];
    assign l2_idx  = vaddr[OFF_W +: L2_IDX_W];
    assign l1_off  = {{(PA_W-L1_IDX_W){1'b0}}, l1_idx} << ENT_SH;
    assign l2_off  = {{(PA_W-L2_IDX_W){1'b0}}, l2_idx} << ENT_SH;
    assign l2_base = {next_frame, {OFF_W{1'b0}}};

    always_comb begin
        if (second_level) begin
            entry_addr = l2_base + l2_off;
        end else begin
            entry_addr = base + l1_off;
        end
    end

    logic unused_offset;
    assign unused_offset = ^vaddr[OFF_W-1:0];

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 30,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [PA_W-1:0]       table_base,
    output logic                  req_ready,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    input  logic                  mem_rsp_valid,
    input  logic                  ent_ok,
    input  logic [PA_W-OFF_W-1:0] ent_frame,
    input  pte_perm_t             ent_perm,
    output logic                  second_level,
    output logic [VA_W-1:0]       vaddr_q,
    output logic [PA_W-1:0]       base_q,
    output logic [PA_W-OFF_W-1:0] l1_frame_q,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic                  rsp_fault_level,
    output logic [PA_W-1:0]       rsp_paddr,
    output pte_perm_t             rsp_perm
);
    walk_state_e state, state_nx;
    logic        issued;
    logic        beat;

    assign beat = issued & mem_rsp_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_L1_READ;
            ST_L1_READ: if (beat) state_nx = ent_ok ? ST_L2_READ : ST_DONE;
            ST_L2_READ: if (beat) state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        second_level  = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_L1_READ: mem_req_valid = ~issued;
            ST_L2_READ: begin
                mem_req_valid = ~issued;
                second_level  = 1'b1;
            end
            ST_DONE:    rsp_valid = 1'b1;
            default:    req_ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issued          <= 1'b0;
            vaddr_q         <= '0;
            base_q          <= '0;
            l1_frame_q      <= '0;
            rsp_fault       <= 1'b0;
            rsp_fault_level <= 1'b0;
            rsp_paddr       <= '0;
            rsp_perm        <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q         <= req_vaddr;
                        base_q          <= table_base;
                        issued          <= 1'b0;
                        rsp_fault       <= 1'b0;
                        rsp_fault_level <= 1'b0;
                        rsp_paddr       <= '0;
                        rsp_perm        <= '0;
                    end
                end
                ST_L1_READ: begin
                    if (mem_req_valid && mem_req_ready) begin
                        issued <= 1'b1;
                    end
                    if (beat) begin
                        issued <= 1'b0;
                        if (ent_ok) begin
                            l1_frame_q <= ent_frame;
                        end else begin
                            rsp_fault       <= 1'b1;
                            rsp_fault_level <= 1'b0;
                        end
                    end
                end
                ST_L2_READ: begin
                    if (mem_req_valid && mem_req_ready) begin
                        issued <= 1'b1;
                    end
                    if (beat) begin
                        issued <= 1'b0;
                        if (ent_ok) begin
                            rsp_paddr <= {ent_frame, vaddr_q[OFF_W-1:0]};
                            rsp_perm  <= ent_perm;
                        end else begin
                            rsp_fault       <= 1'b1;
                            rsp_fault_level <= 1'b1;
                        end
                    end
                end
                ST_DONE: issued <= 1'b0;
                default: issued <= 1'b0;
            endcase
        end
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R6
    fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0 && rsp_perm == '0);

    // R4
    l1_fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_L1_READ && beat && !ent_ok |=> rsp_valid && rsp_fault && !rsp_fault_level);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W     = 32,
    parameter int PA_W     = 30,
    parameter int L1_IDX_W = 10,
    parameter int L2_IDX_W = 10,
    parameter int OFF_W    = 12,
    parameter int PTE_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  table_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic             rsp_fault_level,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_read,
    output logic             rsp_write,
    output logic             rsp_super
);
    localparam int PPN_W = PA_W - OFF_W;

    logic             ent_ok;
    logic [PPN_W-1:0] ent_frame;
    pte_perm_t        ent_perm;
    logic             second_level;
    logic [VA_W-1:0]  vaddr_q;
    logic [PA_W-1:0]  base_q;
    logic [PPN_W-1:0] l1_frame_q;
    pte_perm_t        rsp_perm;

    ptw_pte_decode #(
        .PTE_W(PTE_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_decode (
        .pte      (mem_rsp_data),
        .entry_ok (ent_ok),
        .frame    (ent_frame),
        .perm     (ent_perm)
    );

    ptw_addr_calc #(
        .VA_W(VA_W), .PA_W(PA_W), .L1_IDX_W(L1_IDX_W),
        .L2_IDX_W(L2_IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
    ) u_addr (
        .second_level (second_level),
        .base         (base_q),
        .next_frame   (l1_frame_q),
        .vaddr        (vaddr_q),
        .entry_addr   (mem_req_addr)
    );

    ptw_ctrl #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_vaddr       (req_vaddr),
        .table_base      (table_base),
        .req_ready       (req_ready),
        .mem_req_valid   (mem_req_valid),
        .mem_req_ready   (mem_req_ready),
        .mem_rsp_valid   (mem_rsp_valid),
        .ent_ok          (ent_ok),
        .ent_frame       (ent_frame),
        .ent_perm        (ent_perm),
        .second_level    (second_level),
        .vaddr_q         (vaddr_q),
        .base_q          (base_q),
        .l1_frame_q      (l1_frame_q),
        .rsp_valid       (rsp_valid),
        .rsp_fault       (rsp_fault),
        .rsp_fault_level (rsp_fault_level),
        .rsp_paddr       (rsp_paddr),
        .rsp_perm        (rsp_perm)
    );

    assign rsp_read  = rsp_perm.can_read;
    assign rsp_write = rsp_perm.can_write;
    assign rsp_super = rsp_perm.super_only;

    // R9
    mem_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] table_base = 30'h0000_1000;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        mem_req_valid;
    logic [29:0] mem_req_addr;
    logic        mem_req_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid, rsp_fault, rsp_fault_level;
    logic [29:0] rsp_paddr;
    logic        rsp_read, rsp_write, rsp_super;

    always #5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst_n(rst_n), .table_base(table_base),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_fault_level(rsp_fault_level), .rsp_paddr(rsp_paddr),
        .rsp_read(rsp_read), .rsp_write(rsp_write), .rsp_super(rsp_super)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_rsp_cyc = 0;
    int rec_n = 0;
    logic [29:0] rec_addr [0:3];
    bit stray = 1'b0;
    logic [31:0] mem [logic [29:0]];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [29:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // behavioural memory: random ready stalls and data latency
    initial begin
        bit busy = 1'b0;
        int cnt = 0;
        logic [29:0] aq = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (busy) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(aq);
                    last_rsp_cyc  = cyc;
                    busy = 1'b0;
                end else begin
                    cnt--;
                end
            end else if (stray) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'h0000_3007;
                stray = 1'b0;
            end
            if (busy && mem_req_valid) begin
                chk(1'b0, "R9 request while read outstanding", 1, 0);
            end
            mem_req_ready = (($urandom % 4) != 0);
            if (!busy && mem_req_valid && mem_req_ready) begin
                busy = 1'b1;
                cnt  = $urandom % 4;
                aq   = mem_req_addr;
                if (rec_n < 4) rec_addr[rec_n] = mem_req_addr;
                rec_n++;
            end
        end
    end

    task automatic model(input logic [29:0] base, input logic [31:0] va,
                         output bit fault, output bit lvl, output logic [29:0] pa,
                         output logic [2:0] perm, output int n,
                         output logic [29:0] a1, output logic [29:0] a2);
        logic [31:0] e1, e2;
        a1 = base + {18'h0, va[31:22], 2'b00};
        e1 = rd(a1);
        a2 = '0; pa = '0; perm = '0; lvl = 1'b0;
        if (!e1[0] || e1[31:30] != 2'b00) begin
            fault = 1'b1; n = 1;
        end else begin
            a2 = {e1[29:12], 12'h000} + {18'h0, va[21:12], 2'b00};
            e2 = rd(a2);
            n = 2;
            if (!e2[0] || e2[31:30] != 2'b00) begin
                fault = 1'b1; lvl = 1'b1;
            end else begin
                fault = 1'b0;
                pa = {e2[29:12], va[11:0]};
                perm = e2[3:1];
            end
        end
    endtask

    // kind: 0 L1 invalid, 1 L1 out of range, 2 L2 invalid, 3 L2 out of range, else good
    task automatic build(input logic [29:0] base, input logic [31:0] va, input int kind,
                         input logic [2:0] perm);
        logic [17:0] l2f;
        logic [29:0] a1, a2;
        logic [31:0] e1, e2;
        l2f = 18'h00100 + {8'h0, va[31:22]};
        a1 = base + {18'h0, va[31:22], 2'b00};
        e1 = {2'b00, l2f, 8'($urandom), 3'($urandom), 1'b1};
        if (kind == 0) e1[0] = 1'b0;
        if (kind == 1) e1[31] = 1'b1;
        mem[a1] = e1;
        a2 = {l2f, 12'h000} + {18'h0, va[21:12], 2'b00};
        e2 = {2'b00, 18'($urandom), 8'($urandom), perm, 1'b1};
        if (kind == 2) e2[0] = 1'b0;
        if (kind == 3) e2[30] = 1'b1;
        mem[a2] = e2;
    endtask

    task automatic walk(input logic [31:0] va, input bit noisy);
        logic [29:0] base0;
        bit ef, el;
        logic [29:0] ep, ea1, ea2;
        logic [2:0] eperm;
        int en;
        int waited;
        bit busy_ok;
        base0 = table_base;
        model(base0, va, ef, el, ep, eperm, en, ea1, ea2);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready in idle", req_ready, 1);
        req_valid = 1'b1;
        req_vaddr = va;
        rec_n = 0;
        @(negedge clk);
        if (noisy) begin
            req_vaddr  = ~va;
            table_base = ~base0;
        end else begin
            req_valid = 1'b0;
        end
        waited = 0;
        busy_ok = 1'b1;
        while (!rsp_valid && waited < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            waited++;
        end
        if (noisy) chk(busy_ok, "R2 ready low during walk", !busy_ok, 0);
        chk(rsp_valid, "R8 response arrived", rsp_valid, 1);
        chk(cyc == last_rsp_cyc + 1, "R8 response timing", cyc, last_rsp_cyc + 1);
        chk(rec_n == en, "R4 number of reads", rec_n, en);
        chk(rec_addr[0] == ea1, "R3 first read address", rec_addr[0], ea1);
        if (en == 2) chk(rec_addr[1] == ea2, "R5 second read address", rec_addr[1], ea2);
        chk(rsp_fault == ef, ef ? "R6 fault flag" : "R7 fault flag", rsp_fault, ef);
        if (ef) begin
            chk(rsp_fault_level == el, el ? "R6 fault level" : "R4 fault level",
                rsp_fault_level, el);
        end
        chk(rsp_paddr == ep, ef ? "R6 paddr zero" : "R7 paddr", rsp_paddr, ep);
        chk({rsp_super, rsp_write, rsp_read} == eperm, ef ? "R6 perms zero" : "R7 perms",
            {rsp_super, rsp_write, rsp_read}, eperm);
        req_valid = 1'b0;
        table_base = base0;
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R8 pulse ends and ready returns",
            {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", mem_req_valid, 0);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mem_req_valid && !rsp_valid, "R1 after reset release",
            {req_ready, mem_req_valid, rsp_valid}, 3'b100);

        // directed corner cases
        build(table_base, 32'h0000_0000, 5, 3'b011); walk(32'h0000_0000, 1'b0);
        build(table_base, 32'hFFFF_FFFF, 5, 3'b111); walk(32'hFFFF_FFFF, 1'b0);
        build(table_base, 32'h1234_5678, 0, 3'b001); walk(32'h1234_5678, 1'b0);
        build(table_base, 32'h8765_4321, 1, 3'b001); walk(32'h8765_4321, 1'b0);
        build(table_base, 32'h0040_2ABC, 2, 3'b001); walk(32'h0040_2ABC, 1'b0);
        build(table_base, 32'h7FC0_1FFF, 3, 3'b001); walk(32'h7FC0_1FFF, 1'b0);
        build(table_base, 32'hABCD_E123, 5, 3'b101); walk(32'hABCD_E123, 1'b1);
        table_base = 30'h0002_0004;
        build(table_base, 32'h00C0_3444, 5, 3'b010); walk(32'h00C0_3444, 1'b0);

        // R10: stray data beat in idle
        @(negedge clk);
        stray = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!rsp_valid && !mem_req_valid && req_ready, "R10 stray beat ignored",
                {rsp_valid, mem_req_valid, req_ready}, 3'b001);
        end

        // constrained random walks
        for (int i = 0; i < 60; i++) begin
            logic [31:0] va;
            va = $urandom;
            if (i % 20 == 10) table_base = {18'($urandom % 16), 10'h0, 2'b00};
            build(table_base, va, $urandom % 7, 3'($urandom));
            walk(va, (i % 5) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule